// File: doc/BRIEF.md
# Dual-Channel DAC Serial Command Decoder

This block is the digital front end of a two-channel 10-bit converter. It receives 16-bit command frames over a three-wire serial link made of an active-low chip-select, a serial clock and a data input. It decodes each frame and keeps a double-buffered register pair for each channel: a staging (input) register and an output (DAC) register. It also holds a shutdown flag for each channel, a general-purpose user output, and a choice of serial-clock edge for the data-out pin. Data-out repeats the shifted stream 16 clocks later, so several devices can be chained on one data line.

The serial pins are oversampled by the system clock `clk`. The serial clock must stay at each level for at least two system clock cycles. The analog converter reads the two DAC register values and the shutdown flags from the block's outputs.

Top module: `dacSerialDecoder`

## Requirements
- R1: After reset both DAC registers and both staging registers hold zero, both shutdown flags are clear, the user output is low, data-out is low, and data-out changes on the falling serial-clock edge.
- R2: Data-in is shifted in on each rising serial-clock edge seen while chip-select is low. Serial-clock edges seen while chip-select is high are ignored. A frame with fewer than 16 rising edges has no effect when chip-select rises.
- R3: If a frame has more than 16 rising edges, only the last 16 bits shifted in are decoded.
- R4: Bits are taken MSB first. Frame bits 15..13 form the command, bits 12..3 form the 10-bit data, and bits 2..0 are ignored. Command 001 writes the data to staging register A, and command 101 writes it to staging register B. Neither command changes a DAC register.
- R5: Command 010 writes the data to staging A, and command 110 writes it to staging B. Each then loads both DAC registers from their staging registers, using the newly written value.
- R6: Command 011 writes the data directly into both DAC registers and clears both shutdown flags. The staging registers keep their values.
- R7: Command 100 copies each staging register into its DAC register and clears both shutdown flags.
- R8: With command 000, frame bits 12..9 form a sub-command. Sub-command 0001 copies staging A into DAC A, and 0101 copies staging B into DAC B. Each clears only its own channel's shutdown flag, and the other channel is untouched. Sub-command 0000 changes nothing.
- R9: Command 111 sets both shutdown flags, sub-command 0110 sets the flag of channel A, and sub-command 0111 sets the flag of channel B. Each does so only while the power-down enable input `pdl` is high. Setting a flag leaves the staging and DAC registers unchanged.
- R10: Sub-command 0011 drives the user output high, and sub-command 0010 drives it low.
- R11: Sub-command 100x selects the data-out edge: frame bit 9 = 1 selects the rising edge and 0 selects the falling edge. Data-out is the most significant bit of the 16-bit shift register, so the first bit of a frame appears on data-out after that frame's 16th clock. In rising mode it appears at the 16th rising edge; in falling mode it appears at the falling edge that follows.
- R12: A decoded command takes effect on the first system clock edge at which chip-select is sampled high after being low. While chip-select is low the DAC registers, the flags and the user output do not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rstN | input | 1 | Asynchronous active-low reset |
| csN | input | 1 | Serial chip-select, active low |
| sclk | input | 1 | Serial clock |
| din | input | 1 | Serial data in, MSB first |
| pdl | input | 1 | Power-down enable for the shutdown commands |
| dacA | output | 10 | DAC register of channel A |
| dacB | output | 10 | DAC register of channel B |
| sdA | output | 1 | Shutdown flag of channel A |
| sdB | output | 1 | Shutdown flag of channel B |
| userOut | output | 1 | User-programmable logic output |
| dout | output | 1 | Delayed serial data for chaining |

## Verification
A wrong staging register cannot be seen directly. It shows only when a later copy command (100, 010/110, or sub-command 0001/0101) moves it to a DAC output, one system clock after that frame's chip-select rises. The bench therefore follows every load-only frame with a copy frame. A wrong bit counter or shift alignment shows up as a short frame being accepted or a long frame being mis-decoded, and the DAC outputs reveal it at the next chip-select rise. A wrong edge-mode bit shows on data-out half a serial clock early or late, within the 16th bit of the next frame.

// File: rtl/dacCmdPkg.sv
package dacCmdPkg;
  localparam int NCH = 2;

  // Top-level command codes (frame bits 15..13)
  localparam logic [2:0] CMD_SUB     = 3'b000;
  localparam logic [2:0] CMD_LDA     = 3'b001;
  localparam logic [2:0] CMD_LDA_UPD = 3'b010;
  localparam logic [2:0] CMD_DIRECT  = 3'b011;
  localparam logic [2:0] CMD_UPD_ALL = 3'b100;
  localparam logic [2:0] CMD_LDB     = 3'b101;
  localparam logic [2:0] CMD_LDB_UPD = 3'b110;
  localparam logic [2:0] CMD_SD_ALL  = 3'b111;

  // Sub-commands (frame bits 12..9) under CMD_SUB
  localparam logic [3:0] SUB_NOP   = 4'b0000;
  localparam logic [3:0] SUB_UPDA  = 4'b0001;
  localparam logic [3:0] SUB_UOLO  = 4'b0010;
  localparam logic [3:0] SUB_UOHI  = 4'b0011;
  localparam logic [3:0] SUB_UPDB  = 4'b0101;
  localparam logic [3:0] SUB_SDA   = 4'b0110;
  localparam logic [3:0] SUB_SDB   = 4'b0111;
  localparam logic [2:0] SUB_EDGE  = 3'b100;

  // Strobes from control to datapath, one cycle wide
  typedef struct packed {
    logic [NCH-1:0] loadIn;    // write data into staging register
    logic [NCH-1:0] updDac;    // copy staging (post-write) into DAC
    logic           loadDir;   // write data straight into every DAC
    logic [NCH-1:0] shutDown;  // set shutdown flag (already gated by pdl)
    logic           uoSet;
    logic           uoClr;
    logic           edgeWr;
    logic           edgeRise;
  } dacStrobeT;
endpackage

// File: rtl/dacSerCtrl.sv
module dacSerCtrl
  import dacCmdPkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int DATA_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              din,
  input  logic              pdl,
  input  logic              edgeRise,
  output dacStrobeT         strb,
  output logic [DATA_W-1:0] cmdData,
  output logic              dout
);
  localparam int CNT_W   = $clog2(FRAME_W + 1);
  localparam int CMD_LSB = FRAME_W - 3;
  localparam int DAT_LSB = CMD_LSB - DATA_W;
  localparam int SUB_LSB = CMD_LSB - 4;

  logic               csPrev, sclkPrev;
  logic [FRAME_W-1:0] shiftReg;
  logic [CNT_W-1:0]   bitCnt;
  logic               doutReg;
  logic               sclkRise, sclkFall, csRise, frameOk;
  logic [2:0]         cmd;
  logic [3:0]         sub;

  assign sclkRise = sclk & ~sclkPrev & ~csN;
  assign sclkFall = ~sclk & sclkPrev & ~csN;
  assign csRise   = csN & ~csPrev;
  assign frameOk  = csRise && (bitCnt == CNT_W'(FRAME_W));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      csPrev   <= 1'b1;
      sclkPrev <= 1'b0;
    end else begin
      csPrev   <= csN;
      sclkPrev <= sclk;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      bitCnt   <= '0;
    end else if (csN) begin
      bitCnt <= '0;
    end else if (sclkRise) begin
      shiftReg <= {shiftReg[FRAME_W-2:0], din};
      if (bitCnt != CNT_W'(FRAME_W)) bitCnt <= bitCnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      doutReg <= 1'b0;
    end else if (edgeRise && sclkRise) begin
      doutReg <= shiftReg[FRAME_W-2];
    end else if (!edgeRise && sclkFall) begin
      doutReg <= shiftReg[FRAME_W-1];
    end
  end
  assign dout = doutReg;

  assign cmd     = shiftReg[FRAME_W-1:CMD_LSB];
  assign sub     = shiftReg[CMD_LSB-1:SUB_LSB];
  assign cmdData = shiftReg[CMD_LSB-1:DAT_LSB];

  always_comb begin
    strb = '0;
    if (frameOk) begin
      unique case (cmd)
        CMD_LDA:     strb.loadIn[0] = 1'b1;
        CMD_LDB:     strb.loadIn[1] = 1'b1;
        CMD_LDA_UPD: begin strb.loadIn[0] = 1'b1; strb.updDac = '1; end
        CMD_LDB_UPD: begin strb.loadIn[1] = 1'b1; strb.updDac = '1; end
        CMD_DIRECT:  strb.loadDir = 1'b1;
        CMD_UPD_ALL: strb.updDac = '1;
        CMD_SD_ALL:  strb.shutDown = {NCH{pdl}};
        default: begin
          if (sub[3:1] == SUB_EDGE) begin
            strb.edgeWr   = 1'b1;
            strb.edgeRise = sub[0];
          end else begin
            case (sub)
              SUB_UPDA: strb.updDac[0]   = 1'b1;
              SUB_UPDB: strb.updDac[1]   = 1'b1;
              SUB_SDA:  strb.shutDown[0] = pdl;
              SUB_SDB:  strb.shutDown[1] = pdl;
              SUB_UOLO: strb.uoClr       = 1'b1;
              SUB_UOHI: strb.uoSet       = 1'b1;
              default:  ;
            endcase
          end
        end
      endcase
    end
  end
endmodule

// File: rtl/dacRegFile.sv
module dacRegFile
  import dacCmdPkg::*;
#(
  parameter int DATA_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  dacStrobeT         strb,
  input  logic [DATA_W-1:0] cmdData,
  output logic [DATA_W-1:0] dacOut [NCH],
  output logic [NCH-1:0]    sdFlag,
  output logic              userOut,
  output logic              edgeRise
);
  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [DATA_W-1:0] stageReg, stageNext, dacReg;
    logic              sdReg;

    assign stageNext = strb.loadIn[ch] ? cmdData : stageReg;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        stageReg <= '0;
        dacReg   <= '0;
        sdReg    <= 1'b0;
      end else begin
        stageReg <= stageNext;
        if (strb.loadDir) begin
          dacReg <= cmdData;
          sdReg  <= 1'b0;
        end else if (strb.updDac[ch]) begin
          dacReg <= stageNext;
          sdReg  <= 1'b0;
        end else if (strb.shutDown[ch]) begin
          sdReg  <= 1'b1;
        end
      end
    end

    assign dacOut[ch] = dacReg;
    assign sdFlag[ch] = sdReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      userOut  <= 1'b0;
      edgeRise <= 1'b0;
    end else begin
      if (strb.uoSet) userOut <= 1'b1;
      else if (strb.uoClr) userOut <= 1'b0;
      if (strb.edgeWr) edgeRise <= strb.edgeRise;
    end
  end
endmodule

// File: rtl/dacSerialDecoder.sv
module dacSerialDecoder
  import dacCmdPkg::*;
#(
  parameter int FRAME_W = 16,
  parameter int DATA_W  = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sclk,
  input  logic              din,
  input  logic              pdl,
  output logic [DATA_W-1:0] dacA,
  output logic [DATA_W-1:0] dacB,
  output logic              sdA,
  output logic              sdB,
  output logic              userOut,
  output logic              dout
);
  dacStrobeT         strb;
  logic [DATA_W-1:0] cmdData;
  logic [DATA_W-1:0] dacOut [NCH];
  logic [NCH-1:0]    sdFlag;
  logic              edgeRise;

  dacSerCtrl #(.FRAME_W(FRAME_W), .DATA_W(DATA_W)) i_ctrl (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din), .pdl(pdl),
    .edgeRise(edgeRise), .strb(strb), .cmdData(cmdData), .dout(dout)
  );

  dacRegFile #(.DATA_W(DATA_W)) i_regs (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdData(cmdData),
    .dacOut(dacOut), .sdFlag(sdFlag), .userOut(userOut), .edgeRise(edgeRise)
  );

  assign dacA = dacOut[0];
  assign dacB = dacOut[1];
  assign sdA  = sdFlag[0];
  assign sdB  = sdFlag[1];
endmodule

// File: rtl/dacSerialDecoderChk.sv
module dacSerialDecoderChk #(
  parameter int DATA_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              csN,
  input logic              pdl,
  input logic [DATA_W-1:0] dacA,
  input logic [DATA_W-1:0] dacB,
  input logic              sdA,
  input logic              sdB,
  input logic              userOut,
  input logic              dout
);
  // R12
  dac_a_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csN |=> $stable(dacA));
  // R12
  dac_b_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csN |=> $stable(dacB));
  // R12
  uo_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !csN |=> $stable(userOut));
  // R9
  sd_a_pdl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdA) |-> $past(pdl));
  // R9
  sd_b_pdl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdB) |-> $past(pdl));
  // R8
  upd_a_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dacA) |-> !sdA);
  // R8
  upd_b_wake_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(dacB) |-> !sdB);
  // R2
  dout_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    csN |=> $stable(dout));
endmodule

bind dacSerialDecoder dacSerialDecoderChk #(.DATA_W(DATA_W)) i_chk (.*);

// File: tb/test_dacSerialDecoder.sv
module test_dacSerialDecoder;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       csN = 1'b1, sclk = 1'b0, din = 1'b0, pdl = 1'b0;
  logic [9:0] dacA, dacB;
  logic       sdA, sdB, userOut, dout;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #10 clk = ~clk;

  dacSerialDecoder i_dacSerialDecoder (
    .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .din(din), .pdl(pdl),
    .dacA(dacA), .dacB(dacB), .sdA(sdA), .sdB(sdB), .userOut(userOut), .dout(dout)
  );

  function automatic logic [15:0] mk(input logic [2:0] c, input logic [9:0] d);
    return {c, d, 3'b000};
  endfunction
  function automatic logic [15:0] sc(input logic [3:0] s);
    return {3'b000, s, 6'b0, 3'b000};
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic waitN(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic clockBit(input logic b);
    din = b; sclk = 1'b0; waitN(2);
    sclk = 1'b1; waitN(2);
  endtask

  task automatic sendBits(input logic [31:0] bits, input int n);
    csN = 1'b0; waitN(2);
    for (int i = n - 1; i >= 0; i--) clockBit(bits[i]);
    sclk = 1'b0; waitN(2);
    csN = 1'b1; waitN(3);
  endtask

  task automatic send(input logic [15:0] w);
    sendBits({16'h0, w}, 16);
  endtask

  task automatic chkDac(input string req, input int a, input int b);
    chk({req, " dacA"}, dacA, a);
    chk({req, " dacB"}, dacB, b);
  endtask

  task automatic chkSd(input string req, input logic a, input logic b);
    chk({req, " sdA"}, sdA, a);
    chk({req, " sdB"}, sdB, b);
  endtask

  task automatic testReset();
    chkDac("R1", 0, 0);
    chkSd("R1", 0, 0);
    chk("R1 userOut", userOut, 0);
    chk("R1 dout", dout, 0);
  endtask

  task automatic testLoadOnly();
    send(mk(3'b001, 10'h155));
    chkDac("R4 load A only", 0, 0);
    send(mk(3'b101, 10'h2AA));
    chkDac("R4 load B only", 0, 0);
    send(mk(3'b100, 10'h000));
    chkDac("R7 copy both", 10'h155, 10'h2AA);
  endtask

  task automatic testLoadUpdate();
    send(mk(3'b010, 10'h0F0));
    chkDac("R5 load A update all", 10'h0F0, 10'h2AA);
    send(mk(3'b110, 10'h3FF));
    chkDac("R5 load B update all", 10'h0F0, 10'h3FF);
    send(mk(3'b011, 10'h123));
    chkDac("R6 direct", 10'h123, 10'h123);
  endtask

  task automatic testShutdown();
    pdl = 1'b0;
    send(mk(3'b111, 10'h3FF));
    chkSd("R9 pdl low", 0, 0);
    pdl = 1'b1;
    send(mk(3'b111, 10'h000));
    chkSd("R9 shut all", 1, 1);
    chkDac("R9 dac kept", 10'h123, 10'h123);
    send(mk(3'b100, 10'h000));
    chkDac("R7 staging preserved", 10'h0F0, 10'h3FF);
    chkSd("R7 wake all", 0, 0);
    send(sc(4'b0110));
    chkSd("R9 shut A", 1, 0);
    send(sc(4'b0001));
    chkSd("R8 wake A", 0, 0);
    chkDac("R8 update A", 10'h0F0, 10'h3FF);
    send(sc(4'b0111));
    chkSd("R9 shut B", 0, 1);
    send(mk(3'b011, 10'h001));
    chkSd("R6 wake", 0, 0);
    chkDac("R6 direct", 10'h001, 10'h001);
    send(mk(3'b101, 10'h050));
    send(sc(4'b0110));
    send(sc(4'b0101));
    chkDac("R8 update B", 10'h001, 10'h050);
    chkSd("R8 B only wakes", 1, 0);
    send(sc(4'b0001));
    pdl = 1'b0;
  endtask

  task automatic testUserOut();
    send(sc(4'b0011));
    chk("R10 user high", userOut, 1);
    send(sc(4'b0000));
    chk("R8 nop userOut", userOut, 1);
    chkDac("R8 nop", 10'h0F0, 10'h050);
    send(sc(4'b0010));
    chk("R10 user low", userOut, 0);
  endtask

  task automatic testFraming();
    sendBits({16'h0, 1'b0, mk(3'b011, 10'h200) >> 1}, 15);
    chkDac("R2 short frame", 10'h0F0, 10'h050);
    for (int i = 15; i >= 0; i--) clockBit(mk(3'b011, 10'h3AA) >> i);
    sclk = 1'b0;
    csN = 1'b0; waitN(3); csN = 1'b1; waitN(3);
    chkDac("R2 clocks with cs high", 10'h0F0, 10'h050);
    sendBits({12'h0, 4'hF, mk(3'b011, 10'h0AB)}, 20);
    chkDac("R3 long frame", 10'h0AB, 10'h0AB);
  endtask

  task automatic edgeProbe(input string req, input logic [15:0] w,
                           input logic expMid, input logic expEnd);
    csN = 1'b0; waitN(2);
    for (int i = 15; i >= 1; i--) clockBit(w[i]);
    din = w[0]; sclk = 1'b0; waitN(2);
    sclk = 1'b1; waitN(2);
    chk({req, " dout after 16th rise"}, dout, expMid);
    sclk = 1'b0; waitN(2);
    chk({req, " dout after 16th fall"}, dout, expEnd);
    csN = 1'b1; waitN(3);
  endtask

  task automatic testEdge();
    edgeProbe("R11 falling mode", mk(3'b100, 10'h000), 1'b0, 1'b1);
    send(sc(4'b1001));
    edgeProbe("R11 rising mode", mk(3'b100, 10'h000), 1'b1, 1'b1);
    send(sc(4'b1000));
    edgeProbe("R11 back to falling", mk(3'b100, 10'h000), 1'b0, 1'b1);
    chkDac("R12 frame effect", 10'h0F0, 10'h050);
  endtask

  initial begin
    waitN(3);
    rstN = 1'b1;
    waitN(2);
    testReset();
    testLoadOnly();
    testLoadUpdate();
    testShutdown();
    testUserOut();
    testFraming();
    testEdge();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule